// File: doc/BRIEF.md
# Peak Canceler Allocation Controller

This block controls one stage of a peak-cancellation datapath used for crest-factor reduction. It receives one complex sample per clock when `samp_valid` is high. For each sample it forms the squared magnitude and finds local maxima of that sequence. A maximum whose squared magnitude lies strictly above a programmable detection level counts as a qualifying peak. Each qualifying peak is handed to a free canceler drawn from this stage's share of a shared pool of eight cancelers. The block then issues an assignment event that carries the pool index of that canceler, the target squared magnitude and the active pulse delay.

The stage's share of the pool is taken from four requested per-stage counts. These counts are loaded only when a selectable resource-sync source pulses. An over-subscribed request is refused and a sticky error flag is raised. The pulse delay and the canceler busy length are shadowed in the same way and load only on a cancel-sync pulse. A qualifying peak that finds no free canceler is dropped and counted in a saturating counter. The parameter `STAGE_ID` sets the position of this stage in the pool.

Top module: `pkcan_stage_ctrl`

## Requirements
- R1: After reset, `asg_valid`, `asg_idx`, `asg_target`, `asg_delay`, `missed_cnt` and `alloc_err` are zero, and the active share, delay and length are zero, so every qualifying peak is dropped until a valid resource sync occurs.
- R2: The squared magnitude is I*I+Q*Q on signed two's-complement inputs. Sample n is a peak when its squared magnitude is at least that of sample n-1 and strictly greater than that of sample n+1. A peak is judged only when both earlier samples have been accepted, and its result is registered on the edge that accepts sample n+1. On a plateau of equal values followed by a drop, only the last sample of the plateau is a peak.
- R3: A peak qualifies only when its squared magnitude is strictly greater than `det_thr`. A peak equal to `det_thr` causes neither an assignment nor a miss.
- R4: A qualifying peak takes the lowest-numbered free local canceler k (k < active count). `asg_idx` = active base + k, where the base is the sum of the counts of the stages numbered below `STAGE_ID`. `asg_target` is `gain_thr` and `asg_delay` is the active delay, both as they stand at that edge.
- R5: A canceler assigned at edge E with active length L is not assigned again before edge E+L+1.
- R6: A qualifying peak with no free canceler raises no event and increments `missed_cnt` by one. The counter saturates at 2^MISS_W-1.
- R7: `req_cnt` (stage s in bits [4s+3:4s]) is loaded into the active share only on an edge where `rsync_src[rsync_sel]` is high. Pulses on the other sources are ignored.
- R8: When the four requested counts sum to more than 8 at a resource sync, the previous share is kept and `alloc_err` is set. `alloc_err` stays set until reset.
- R9: `req_delay` and `req_len` become active only on an edge where `cancel_sync` is high. A requested delay below 5 is loaded as 5.
- R10: When a resource sync and an assignment fall on the same edge, the assignment uses the share that was active before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Sample accepted this cycle |
| samp_i | input | 8 | In-phase sample, signed |
| samp_q | input | 8 | Quadrature sample, signed |
| det_thr | input | 16 | Detection level (squared magnitude) |
| gain_thr | input | 16 | Target squared magnitude for cancelled peaks |
| req_cnt | input | 16 | Requested canceler counts, 4 bits per stage |
| rsync_sel | input | 2 | Selects the resource-sync source |
| rsync_src | input | 4 | Candidate resource-sync pulses |
| cancel_sync | input | 1 | Loads requested delay and length |
| req_delay | input | 8 | Requested pulse delay in samples |
| req_len | input | 8 | Requested canceler busy length in clocks |
| asg_valid | output | 1 | Assignment event |
| asg_idx | output | 3 | Pool index of the assigned canceler |
| asg_target | output | 16 | Target squared magnitude of the event |
| asg_delay | output | 8 | Pulse delay of the event |
| missed_cnt | output | MISS_W | Saturating count of dropped peaks |
| alloc_err | output | 1 | Sticky over-allocation flag |

## Verification
The assignment of a peak and the reload of this stage's share can fall on the same clock edge. To provoke this, the bench raises the selected resource-sync source on exactly the step that completes a peak, while a new request is pending that moves the base from 0 to 3. The event on that edge must carry pool index 0, taken from the old share. The peak that follows at once must carry index 4: the new base plus local slot 1, because slot 0 is still busy.

// File: rtl/pkcan_pkg.sv
package pkcan_pkg;
    localparam int SAMP_W = 8;
    localparam int MAG_W  = 2 * SAMP_W;
    localparam int NCAN   = 8;
    localparam int NSTAGE = 4;
    localparam int CNT_W  = $clog2(NCAN + 1);
    localparam int IDX_W  = $clog2(NCAN);
    localparam int SUM_W  = CNT_W + $clog2(NSTAGE);
    localparam int DLY_W  = 8;
    localparam int LEN_W  = 8;
    localparam logic [DLY_W-1:0] MIN_DLY = DLY_W'(5);

    // share of the pool owned by this stage
    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] cnt;
    } alloc_t;

    // how many samples the detector history holds
    typedef enum logic [1:0] {H_EMPTY, H_ONE, H_FULL} hist_e;

    function automatic logic [MAG_W-1:0] mag_sq(input logic signed [SAMP_W-1:0] a,
                                                 input logic signed [SAMP_W-1:0] b);
        logic signed [MAG_W-1:0] pa;
        logic signed [MAG_W-1:0] pb;
        pa = MAG_W'(a);
        pb = MAG_W'(b);
        pa = pa * pa;
        pb = pb * pb;
        return $unsigned(pa) + $unsigned(pb);
    endfunction

    function automatic logic [DLY_W-1:0] clamp_delay(input logic [DLY_W-1:0] d);
        return (d < MIN_DLY) ? MIN_DLY : d;
    endfunction
endpackage

// File: rtl/pkcan_peak_det.sv
module pkcan_peak_det import pkcan_pkg::*; (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic signed [SAMP_W-1:0] samp_q,
    input  logic [MAG_W-1:0]         det_thr,
    output logic                     peak_hit
);
    logic [MAG_W-1:0] mag_in;
    logic [MAG_W-1:0] mag_cur;
    logic [MAG_W-1:0] mag_prev;
    hist_e            hist;

    assign mag_in = mag_sq(samp_i, samp_q);

    // candidate is the held sample; the incoming one is its right neighbour
    assign peak_hit = samp_valid && (hist == H_FULL) &&
                      (mag_cur >= mag_prev) && (mag_cur > mag_in) &&
                      (mag_cur > det_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_cur  <= '0;
            mag_prev <= '0;
            hist     <= H_EMPTY;
        end else if (samp_valid) begin
            mag_prev <= mag_cur;
            mag_cur  <= mag_in;
            case (hist)
                H_EMPTY: hist <= H_ONE;
                default: hist <= H_FULL;
            endcase
        end
    end

    // a peak is strictly above its successor, so the successor is never one
    assert_no_adjacent_R2: assert property (@(posedge clk) disable iff (rst)
        peak_hit |=> !peak_hit);
endmodule

// File: rtl/pkcan_sync_cfg.sv
module pkcan_sync_cfg import pkcan_pkg::*; #(
    parameter int STAGE_ID = 0,
    parameter int NSRC     = 4,
    parameter int SEL_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSTAGE*CNT_W-1:0] req_cnt,
    input  logic [SEL_W-1:0]        rsync_sel,
    input  logic [NSRC-1:0]         rsync_src,
    input  logic                    cancel_sync,
    input  logic [DLY_W-1:0]        req_delay,
    input  logic [LEN_W-1:0]        req_len,
    output alloc_t                  act,
    output logic [DLY_W-1:0]        act_delay,
    output logic [LEN_W-1:0]        act_len,
    output logic                    alloc_err
);
    logic             res_evt;
    logic [SUM_W-1:0] req_sum;
    logic [SUM_W-1:0] req_base;
    logic             req_ok;

    assign res_evt = rsync_src[rsync_sel];

    always_comb begin
        req_sum  = '0;
        req_base = '0;
        for (int s = 0; s < NSTAGE; s++) begin
            if (s < STAGE_ID)
                req_base = req_base + SUM_W'(req_cnt[s*CNT_W +: CNT_W]);
            req_sum = req_sum + SUM_W'(req_cnt[s*CNT_W +: CNT_W]);
        end
    end

    assign req_ok = (req_sum <= SUM_W'(NCAN));

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= '0;
            alloc_err <= 1'b0;
        end else if (res_evt) begin
            if (req_ok) begin
                act.base <= CNT_W'(req_base);
                act.cnt  <= req_cnt[STAGE_ID*CNT_W +: CNT_W];
            end else begin
                alloc_err <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_delay <= '0;
            act_len   <= '0;
        end else if (cancel_sync) begin
            act_delay <= clamp_delay(req_delay);
            act_len   <= req_len;
        end
    end

    assert_share_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !res_evt |=> $stable(act));
    assert_share_fits_R8: assert property (@(posedge clk) disable iff (rst)
        (SUM_W'(act.base) + SUM_W'(act.cnt)) <= SUM_W'(NCAN));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        alloc_err |=> alloc_err);
    assert_delay_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cancel_sync |=> ($stable(act_delay) && $stable(act_len)));
    assert_delay_floor_R9: assert property (@(posedge clk) disable iff (rst)
        (act_delay == '0) || (act_delay >= MIN_DLY));
endmodule

// File: rtl/pkcan_pool.sv
module pkcan_pool import pkcan_pkg::*; #(
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              peak_hit,
    input  alloc_t            alloc,
    input  logic [DLY_W-1:0]  act_delay,
    input  logic [LEN_W-1:0]  act_len,
    input  logic [MAG_W-1:0]  gain_thr,
    output logic              asg_valid,
    output logic [IDX_W-1:0]  asg_idx,
    output logic [MAG_W-1:0]  asg_target,
    output logic [DLY_W-1:0]  asg_delay,
    output logic [MISS_W-1:0] missed_cnt
);
    logic [NCAN-1:0][LEN_W-1:0] timer;
    logic [NCAN-1:0]            free;
    logic [IDX_W-1:0]           gslot;
    logic                       gfound;
    logic                       take;

    generate
        for (genvar k = 0; k < NCAN; k++) begin : g_free
            assign free[k] = (CNT_W'(k) < alloc.cnt) && (timer[k] == '0);
        end
    endgenerate

    // lowest-numbered free slot wins
    always_comb begin
        gslot  = '0;
        gfound = 1'b0;
        for (int k = NCAN - 1; k >= 0; k--) begin
            if (free[k]) begin
                gfound = 1'b1;
                gslot  = IDX_W'(k);
            end
        end
    end

    assign take = peak_hit && gfound;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer <= '0;
        end else begin
            for (int k = 0; k < NCAN; k++) begin
                if (take && (gslot == IDX_W'(k)))
                    timer[k] <= act_len;
                else if (timer[k] != '0)
                    timer[k] <= timer[k] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asg_valid  <= 1'b0;
            asg_idx    <= '0;
            asg_target <= '0;
            asg_delay  <= '0;
            missed_cnt <= '0;
        end else begin
            asg_valid <= take;
            if (take) begin
                asg_idx    <= IDX_W'(alloc.base + CNT_W'(gslot));
                asg_target <= gain_thr;
                asg_delay  <= act_delay;
            end
            if (peak_hit && !gfound && (missed_cnt != '1))
                missed_cnt <= missed_cnt + 1'b1;
        end
    end

    assert_idx_in_share_R4: assert property (@(posedge clk) disable iff (rst)
        asg_valid |-> ((CNT_W'(asg_idx) >= $past(alloc.base)) &&
                       (CNT_W'(asg_idx) < ($past(alloc.base) + $past(alloc.cnt)))));
    assert_miss_step_R6: assert property (@(posedge clk) disable iff (rst)
        MISS_W'(missed_cnt - $past(missed_cnt)) <= MISS_W'(1));
    assert_miss_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (missed_cnt == '1) |=> (missed_cnt == '1));
    assert_event_not_missed_R6: assert property (@(posedge clk) disable iff (rst)
        asg_valid |-> (missed_cnt == $past(missed_cnt)));
endmodule

// File: rtl/pkcan_stage_ctrl.sv
module pkcan_stage_ctrl import pkcan_pkg::*; #(
    parameter int STAGE_ID = 0,
    parameter int NSRC     = 4,
    parameter int MISS_W   = 8,
    localparam int SEL_W   = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp_i,
    input  logic signed [SAMP_W-1:0] samp_q,
    input  logic [MAG_W-1:0]         det_thr,
    input  logic [MAG_W-1:0]         gain_thr,
    input  logic [NSTAGE*CNT_W-1:0]  req_cnt,
    input  logic [SEL_W-1:0]         rsync_sel,
    input  logic [NSRC-1:0]          rsync_src,
    input  logic                     cancel_sync,
    input  logic [DLY_W-1:0]         req_delay,
    input  logic [LEN_W-1:0]         req_len,
    output logic                     asg_valid,
    output logic [IDX_W-1:0]         asg_idx,
    output logic [MAG_W-1:0]         asg_target,
    output logic [DLY_W-1:0]         asg_delay,
    output logic [MISS_W-1:0]        missed_cnt,
    output logic                     alloc_err
);
    logic             peak_hit;
    alloc_t           act;
    logic [DLY_W-1:0] act_delay;
    logic [LEN_W-1:0] act_len;

    pkcan_peak_det u_det (
        .clk        (clk),
        .rst        (rst),
        .samp_valid (samp_valid),
        .samp_i     (samp_i),
        .samp_q     (samp_q),
        .det_thr    (det_thr),
        .peak_hit   (peak_hit)
    );

    pkcan_sync_cfg #(
        .STAGE_ID (STAGE_ID),
        .NSRC     (NSRC),
        .SEL_W    (SEL_W)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .req_cnt     (req_cnt),
        .rsync_sel   (rsync_sel),
        .rsync_src   (rsync_src),
        .cancel_sync (cancel_sync),
        .req_delay   (req_delay),
        .req_len     (req_len),
        .act         (act),
        .act_delay   (act_delay),
        .act_len     (act_len),
        .alloc_err   (alloc_err)
    );

    pkcan_pool #(
        .MISS_W (MISS_W)
    ) u_pool (
        .clk        (clk),
        .rst        (rst),
        .peak_hit   (peak_hit),
        .alloc      (act),
        .act_delay  (act_delay),
        .act_len    (act_len),
        .gain_thr   (gain_thr),
        .asg_valid  (asg_valid),
        .asg_idx    (asg_idx),
        .asg_target (asg_target),
        .asg_delay  (asg_delay),
        .missed_cnt (missed_cnt)
    );
endmodule

// File: tb/sim_pkcan_stage_ctrl.sv
`timescale 1ns/1ps
module sim_pkcan_stage_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_valid = 1'b0;
    logic [7:0]  samp_i = '0;
    logic [7:0]  samp_q = '0;
    logic [15:0] det_thr = '0;
    logic [15:0] gain_thr = '0;
    logic [15:0] req_cnt = '0;
    logic [1:0]  rsync_sel = '0;
    logic [3:0]  rsync_src = '0;
    logic        cancel_sync = 1'b0;
    logic [7:0]  req_delay = '0;
    logic [7:0]  req_len = '0;
    logic        asg_valid;
    logic [2:0]  asg_idx;
    logic [15:0] asg_target;
    logic [7:0]  asg_delay;
    logic [2:0]  missed_cnt;
    logic        alloc_err;

    logic [3:0] pend_rs = '0;
    logic       pend_cs = 1'b0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pkcan_stage_ctrl #(.STAGE_ID(1), .NSRC(4), .MISS_W(3)) u0 (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_i(samp_i), .samp_q(samp_q),
        .det_thr(det_thr), .gain_thr(gain_thr), .req_cnt(req_cnt), .rsync_sel(rsync_sel),
        .rsync_src(rsync_src), .cancel_sync(cancel_sync), .req_delay(req_delay),
        .req_len(req_len), .asg_valid(asg_valid), .asg_idx(asg_idx), .asg_target(asg_target),
        .asg_delay(asg_delay), .missed_cnt(missed_cnt), .alloc_err(alloc_err)
    );

    // one row per sample: input, then the event expected after that step
    typedef struct packed {
        logic [7:0] i;
        logic [7:0] q;
        logic       ev;
        logic [2:0] idx;
        logic [2:0] miss;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{8'd0,   8'd0,   1'b0, 3'd0, 3'd1},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd1},
        '{8'd2,   8'd0,   1'b1, 3'd2, 3'd1},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd1},
        '{8'd2,   8'd0,   1'b1, 3'd3, 3'd1},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd1},
        '{8'd2,   8'd0,   1'b1, 3'd4, 3'd1},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd1},
        '{8'd2,   8'd0,   1'b0, 3'd0, 3'd2},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd2},
        '{8'd2,   8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd2,   8'd0,   1'b1, 3'd2, 3'd3},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd2,   8'd0,   1'b1, 3'd3, 3'd3},
        '{8'hFA,  8'd8,   1'b0, 3'd0, 3'd3},
        '{8'd1,   8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd10,  8'hFF,  1'b0, 3'd0, 3'd3},
        '{8'd0,   8'd0,   1'b1, 3'd4, 3'd3},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd20,  8'd0,   1'b0, 3'd0, 3'd3},
        '{8'd0,   8'd0,   1'b1, 3'd2, 3'd3}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] i, input logic [7:0] q, input logic v);
        @(negedge clk);
        samp_i      = i;
        samp_q      = q;
        samp_valid  = v;
        rsync_src   = pend_rs;
        cancel_sync = pend_cs;
        pend_rs     = '0;
        pend_cs     = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(8'd0, 8'd0, 1'b0);
    endtask

    task automatic do_peak(input string req, input bit ev, input int idx,
                           input int dly, input int tgt, input int miss);
        step(8'd0, 8'd0, 1'b1);
        step(8'd20, 8'd0, 1'b1);
        step(8'd0, 8'd0, 1'b1);
        chk(req, "asg_valid", asg_valid, ev);
        if (ev) begin
            chk(req, "asg_idx", asg_idx, idx);
            chk(req, "asg_delay", asg_delay, dly);
            chk(req, "asg_target", asg_target, tgt);
        end
        chk(req, "missed_cnt", missed_cnt, miss);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "asg_valid", asg_valid, 0);
        chk("R1", "missed_cnt", missed_cnt, 0);
        chk("R1", "alloc_err", alloc_err, 0);
        chk("R1", "asg_delay", asg_delay, 0);
        chk("R1", "asg_target", asg_target, 0);

        // R7: requests pending, only a non-selected source pulses
        det_thr   = 16'd100;
        gain_thr  = 16'd77;
        req_cnt   = 16'h0032;          // stage0=2, stage1=3
        req_delay = 8'd20;
        req_len   = 8'd8;
        rsync_sel = 2'd2;
        pend_rs   = 4'b0001;
        idle(1);
        // R1: zero share after reset, so the peak is dropped
        do_peak("R1", 1'b0, 0, 0, 0, 1);

        // R7/R9: selected source and cancel sync together
        pend_rs = 4'b0100;
        pend_cs = 1'b1;
        idle(1);

        // R2 R3 R4 R5 R6: vector walk
        for (int r = 0; r < NVEC; r++) begin
            step(VEC[r].i, VEC[r].q, 1'b1);
            chk("R2/R4/R5", $sformatf("row%0d asg_valid", r), asg_valid, VEC[r].ev);
            if (VEC[r].ev) begin
                chk("R4", $sformatf("row%0d asg_idx", r), asg_idx, VEC[r].idx);
                chk("R4", $sformatf("row%0d asg_target", r), asg_target, 77);
                chk("R9", $sformatf("row%0d asg_delay", r), asg_delay, 20);
            end
            chk("R6/R3", $sformatf("row%0d missed_cnt", r), missed_cnt, VEC[r].miss);
        end

        // R9: new delay without cancel sync is not used
        req_delay = 8'd3;
        idle(12);
        do_peak("R9", 1'b1, 2, 20, 77, 3);
        // R9: after cancel sync the delay is raised to 5; R4 gain is live
        gain_thr = 16'd55;
        pend_cs  = 1'b1;
        idle(12);
        do_peak("R9", 1'b1, 2, 5, 55, 3);

        // R8: over-subscribed request is refused
        req_cnt = 16'h0045;            // 5 + 4 = 9
        pend_rs = 4'b0100;
        idle(1);
        chk("R8", "alloc_err", alloc_err, 1);
        idle(12);
        do_peak("R8", 1'b1, 2, 5, 55, 3);
        // R8: valid request accepted, flag stays set
        req_cnt = 16'h0010;            // stage0=0, stage1=1
        pend_rs = 4'b0100;
        idle(1);
        chk("R8", "alloc_err sticky", alloc_err, 1);
        idle(12);
        do_peak("R4", 1'b1, 0, 5, 55, 3);
        // R5 R6: the only canceler is still busy
        do_peak("R5", 1'b0, 0, 0, 0, 4);

        // R10: resource sync on the same edge as the assignment
        idle(12);
        req_cnt = 16'h0023;            // stage0=3, stage1=2
        step(8'd0, 8'd0, 1'b1);
        step(8'd20, 8'd0, 1'b1);
        pend_rs = 4'b0100;
        step(8'd0, 8'd0, 1'b1);
        chk("R10", "asg_valid", asg_valid, 1);
        chk("R10", "asg_idx old share", asg_idx, 0);
        do_peak("R10", 1'b1, 4, 5, 55, 4);

        // R6: saturation with an empty share
        req_cnt = 16'h0003;            // stage1=0
        pend_rs = 4'b0100;
        idle(12);
        for (int n = 0; n < 6; n++) begin
            step(8'd0, 8'd0, 1'b1);
            step(8'd20, 8'd0, 1'b1);
            step(8'd0, 8'd0, 1'b1);
        end
        chk("R6", "asg_valid", asg_valid, 0);
        chk("R6", "missed_cnt saturated", missed_cnt, 7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule